// File: doc/BRIEF.md
# Pipelined CORDIC Cartesian-to-Polar Converter

This block takes a signed complex baseband sample, an in-phase value and a quadrature value, and returns its magnitude and angle. It uses a pipelined CORDIC in vectoring mode, so the only arithmetic is addition, subtraction and arithmetic shifts. A new sample can enter on every clock, and each result leaves a fixed number of cycles later.

Before the iterations start, the input stage takes the absolute value of both components. This moves every sample into the first quadrant, so the iterations only ever see angles from 0 to a right angle. The two original sign bits are recorded as flags. They travel through the pipe next to the data, so that later stages can put the signs back and rebuild the full-circle angle.

The magnitude leaves with the CORDIC gain still applied, a factor of about 1.6468. A downstream multiplier removes it using the fixed reciprocal constant exported by the package. With the default parameters, the angle word uses 256 for a right angle.

Top module: `cordic_polar_conv`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0.
- R2: Every sample accepted with `in_valid` high shows up as `out_valid` high exactly N_ITER+1 rising edges after it was captured (9 with defaults). This holds for back-to-back samples, with one result per cycle and none dropped.
- R3: With each result, `out_i_neg` equals the sign bit of that sample's `in_i` and `out_q_neg` equals the sign bit of its `in_q` (1 means negative).
- R4: `out_phase` always lies in the range 0 to 256. The value 0 is angle zero and 256 is a right angle, so a phase code is the angle times 512/pi.
- R5: When the input radius sqrt(I^2+Q^2) is at least 16, `out_mag` is within 6 + mag/32 of 1.6468 times the radius.
- R6: When the input radius is at least 64, `out_phase` is within 5 codes of atan(|Q|/|I|)*512/pi.
- R7: Samples with the same |I| and |Q| but different signs give identical `out_mag` and `out_phase`.
- R8: While `out_valid` is low, `out_mag`, `out_phase`, `out_i_neg` and `out_q_neg` keep the values they held in the previous cycle.
- R9: An all-zero input sample gives `out_mag` equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| in_valid | input | 1 | Qualifies `in_i` and `in_q` in this cycle |
| in_i | input | IN_W (8) | In-phase sample, two's complement |
| in_q | input | IN_W (8) | Quadrature sample, two's complement |
| out_valid | output | 1 | Result on the outputs is new in this cycle |
| out_mag | output | DW (10) | Magnitude times the CORDIC gain, unsigned |
| out_phase | output | DW-1 (9) | First-quadrant angle, 256 is a right angle |
| out_i_neg | output | 1 | Sign of the original in-phase sample |
| out_q_neg | output | 1 | Sign of the original quadrature sample |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- Samples on the axes and on the diagonal push the accumulated angle just below zero or just above a right angle. A missing clamp would report a phase outside 0 to 256.
- The most negative input, -128 on either or both components, exposes a fold that overflows its absolute value. That fault produces a wrong magnitude and a mirror-image mismatch with +127/+128.
- Sending all four sign variants of the same pair back to back catches flags that drift relative to their data. It also catches sign recovery applied twice.
- Bursts of consecutive samples with gaps between them find a valid or enable path that is one stage short or long. They also find outputs that change while no result is flagged.

// File: rtl/cvp_pkg.sv
package cvp_pkg;

  // Sign record carried beside each sample through the pipe
  typedef struct packed {
    logic neg_i;
    logic neg_q;
  } quad_flags_t;

  // Reciprocal of the vectoring gain (0.60725) in Q10, for the downstream normaliser
  localparam int unsigned GAIN_INV_Q10 = 622;

  // atan(2^-idx) in codes where a right angle is 256, rescaled to half_pi
  function automatic int atan_code(input int idx, input int half_pi);
    int base;
    case (idx)
      0:       base = 128;
      1:       base = 76;
      2:       base = 40;
      3:       base = 20;
      4:       base = 10;
      5:       base = 5;
      6:       base = 3;
      7:       base = 1;
      8:       base = 1;
      default: base = 0;
    endcase
    return (base * half_pi + 128) / 256;
  endfunction

endpackage

// File: rtl/cvp_fold.sv
module cvp_fold #(
  parameter int IN_W = 8,
  parameter int DW   = 10,
  parameter int ZW   = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [IN_W-1:0]         in_i,
  input  logic [IN_W-1:0]         in_q,
  output logic                    v_o,
  output logic signed [DW-1:0]    x_o,
  output logic signed [DW-1:0]    y_o,
  output logic signed [ZW-1:0]    z_o,
  output cvp_pkg::quad_flags_t    f_o
);
  localparam int EXT = DW - IN_W;

  logic signed [DW-1:0]  i_ext, q_ext, x_nx, y_nx;
  cvp_pkg::quad_flags_t  f_nx;

  // next-state: sign-extend, record signs, take magnitudes
  always_comb begin
    i_ext      = {{EXT{in_i[IN_W-1]}}, in_i};
    q_ext      = {{EXT{in_q[IN_W-1]}}, in_q};
    f_nx.neg_i = in_i[IN_W-1];
    f_nx.neg_q = in_q[IN_W-1];
    x_nx       = f_nx.neg_i ? -i_ext : i_ext;
    y_nx       = f_nx.neg_q ? -q_ext : q_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
    end else begin
      v_o <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
      f_o <= '0;
    end else if (in_valid) begin
      x_o <= x_nx;
      y_o <= y_nx;
      z_o <= '0;
      f_o <= f_nx;
    end
  end
endmodule

// File: rtl/cvp_stage.sv
module cvp_stage #(
  parameter int DW    = 10,
  parameter int ZW    = 11,
  parameter int IDX   = 0,
  parameter int ANGLE = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    v_i,
  input  logic signed [DW-1:0]    x_i,
  input  logic signed [DW-1:0]    y_i,
  input  logic signed [ZW-1:0]    z_i,
  input  cvp_pkg::quad_flags_t    f_i,
  output logic                    v_o,
  output logic signed [DW-1:0]    x_o,
  output logic signed [DW-1:0]    y_o,
  output logic signed [ZW-1:0]    z_o,
  output cvp_pkg::quad_flags_t    f_o
);
  localparam logic signed [ZW-1:0] ANG = ZW'(ANGLE);

  logic                 y_neg;
  logic signed [DW-1:0] x_sh, y_sh, x_nx, y_nx;
  logic signed [ZW-1:0] z_nx;

  // next-state: one micro-rotation toward the x axis
  always_comb begin
    y_neg = y_i[DW-1];
    x_sh  = x_i >>> IDX;
    y_sh  = y_i >>> IDX;
    if (y_neg) begin
      x_nx = x_i - y_sh;
      y_nx = y_i + x_sh;
      z_nx = z_i - ANG;
    end else begin
      x_nx = x_i + y_sh;
      y_nx = y_i - x_sh;
      z_nx = z_i + ANG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
    end else begin
      v_o <= v_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
      f_o <= '0;
    end else if (v_i) begin
      x_o <= x_nx;
      y_o <= y_nx;
      z_o <= z_nx;
      f_o <= f_i;
    end
  end
endmodule

// File: rtl/cvp_phase_sat.sv
module cvp_phase_sat #(
  parameter int ZW      = 11,
  parameter int PW      = 9,
  parameter int HALF_PI = 256
) (
  input  logic signed [ZW-1:0] z_i,
  output logic [PW-1:0]        ph_o
);
  localparam logic signed [ZW-1:0] HP = ZW'(HALF_PI);

  // residual error can push the angle a little past either end
  always_comb begin
    if (z_i[ZW-1]) begin
      ph_o = '0;
    end else if (z_i > HP) begin
      ph_o = PW'(HALF_PI);
    end else begin
      ph_o = z_i[PW-1:0];
    end
  end
endmodule

// File: rtl/cordic_polar_conv.sv
module cordic_polar_conv #(
  parameter int IN_W   = 8,
  parameter int DW     = 10,
  parameter int N_ITER = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_i,
  input  logic [IN_W-1:0]  in_q,
  output logic             out_valid,
  output logic [DW-1:0]    out_mag,
  output logic [DW-2:0]    out_phase,
  output logic             out_i_neg,
  output logic             out_q_neg
);
  localparam int ZW      = DW + 1;
  localparam int PW      = DW - 1;
  localparam int HALF_PI = 2 ** (DW - 2);

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic                  v_p [N_ITER+1];
  logic signed [DW-1:0]  x_p [N_ITER+1];
  logic signed [DW-1:0]  y_p [N_ITER+1];
  logic signed [ZW-1:0]  z_p [N_ITER+1];
  cvp_pkg::quad_flags_t  f_p [N_ITER+1];

  cvp_fold #(.IN_W(IN_W), .DW(DW), .ZW(ZW)) u_fold (
    .clk(clk), .rst_n(rst_q), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q),
    .v_o(v_p[0]), .x_o(x_p[0]), .y_o(y_p[0]), .z_o(z_p[0]), .f_o(f_p[0])
  );

  for (genvar g = 0; g < N_ITER; g++) begin : g_iter
    cvp_stage #(
      .DW(DW), .ZW(ZW), .IDX(g),
      .ANGLE(cvp_pkg::atan_code(g, HALF_PI))
    ) u_stage (
      .clk(clk), .rst_n(rst_q),
      .v_i(v_p[g]),   .x_i(x_p[g]),   .y_i(y_p[g]),   .z_i(z_p[g]),   .f_i(f_p[g]),
      .v_o(v_p[g+1]), .x_o(x_p[g+1]), .y_o(y_p[g+1]), .z_o(z_p[g+1]), .f_o(f_p[g+1])
    );
  end

  cvp_phase_sat #(.ZW(ZW), .PW(PW), .HALF_PI(HALF_PI)) u_sat (
    .z_i(z_p[N_ITER]), .ph_o(out_phase)
  );

  assign out_valid = v_p[N_ITER];
  assign out_mag   = x_p[N_ITER];
  assign out_i_neg = f_p[N_ITER].neg_i;
  assign out_q_neg = f_p[N_ITER].neg_q;

  // y of the last stage is the residual and is not needed downstream
  logic unused_y;
  assign unused_y = ^y_p[N_ITER];
endmodule

// File: rtl/cordic_polar_conv_chk.sv
module cordic_polar_conv_chk #(
  parameter int IN_W   = 8,
  parameter int DW     = 10,
  parameter int N_ITER = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_q,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_i,
  input logic [IN_W-1:0]  in_q,
  input logic             out_valid,
  input logic [DW-1:0]    out_mag,
  input logic [DW-2:0]    out_phase,
  input logic             out_i_neg,
  input logic             out_q_neg
);
  localparam int HALF_PI = 2 ** (DW - 2);
  localparam int LAT     = N_ITER + 1;

  logic pv [LAT];
  logic pni[LAT];
  logic pnq[LAT];
  logic pz [LAT];

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      for (int k = 0; k < LAT; k++) begin
        pv[k] <= 1'b0; pni[k] <= 1'b0; pnq[k] <= 1'b0; pz[k] <= 1'b0;
      end
    end else begin
      pv[0]  <= in_valid;
      pni[0] <= in_i[IN_W-1];
      pnq[0] <= in_q[IN_W-1];
      pz[0]  <= (in_i == '0) && (in_q == '0);
      for (int k = 1; k < LAT; k++) begin
        pv[k] <= pv[k-1]; pni[k] <= pni[k-1]; pnq[k] <= pnq[k-1]; pz[k] <= pz[k-1];
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> !out_valid);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid == pv[LAT-1]);

  assert_flags_R3: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> (out_i_neg == pni[LAT-1]) && (out_q_neg == pnq[LAT-1]));

  assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> (int'(out_phase) <= HALF_PI));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_q)
    !out_valid |-> $stable(out_mag) && $stable(out_phase)
                   && $stable(out_i_neg) && $stable(out_q_neg));

  assert_zero_mag_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && pz[LAT-1]) |-> (out_mag == '0));
endmodule

bind cordic_polar_conv cordic_polar_conv_chk #(
  .IN_W(IN_W), .DW(DW), .N_ITER(N_ITER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_q(rst_q),
  .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .out_valid(out_valid), .out_mag(out_mag), .out_phase(out_phase),
  .out_i_neg(out_i_neg), .out_q_neg(out_q_neg)
);

// File: tb/cordic_polar_conv_test.sv
module cordic_polar_conv_test;
  localparam int LAT = 9;
  localparam real PI = 3.14159265358979;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_i, in_q;
  logic       out_valid;
  logic [9:0] out_mag;
  logic [8:0] out_phase;
  logic       out_i_neg, out_q_neg;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit mon_on = 0;

  always #4 clk = ~clk;

  cordic_polar_conv uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_mag(out_mag), .out_phase(out_phase),
    .out_i_neg(out_i_neg), .out_q_neg(out_q_neg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference history of captured samples, index 0 is newest
  bit hv [LAT];
  int hi [LAT];
  int hq [LAT];
  int prev_mag, prev_ph, prev_ni, prev_nq;
  int last_ai = -1, last_aq = -1, last_mag, last_ph;

  initial begin
    for (int k = 0; k < LAT; k++) begin hv[k] = 0; hi[k] = 0; hq[k] = 0; end
    forever begin
      @(posedge clk);
      #2;
      if (mon_on) begin
        for (int k = LAT-1; k > 0; k--) begin hv[k] = hv[k-1]; hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
        hv[0] = in_valid;
        hi[0] = $signed(in_i);
        hq[0] = $signed(in_q);
        chk(out_valid == hv[LAT-1], "R2 valid latency", out_valid, hv[LAT-1]);
        if (out_valid) begin
          int ei, eq, ai, aq;
          real r, em, ep;
          ei = hi[LAT-1]; eq = hq[LAT-1];
          ai = (ei < 0) ? -ei : ei;
          aq = (eq < 0) ? -eq : eq;
          r  = $sqrt(real'(ai*ai + aq*aq));
          em = 1.6468 * r;
          chk(out_i_neg == (ei < 0), "R3 i sign flag", out_i_neg, ei < 0);
          chk(out_q_neg == (eq < 0), "R3 q sign flag", out_q_neg, eq < 0);
          chk(out_phase <= 256, "R4 phase range", out_phase, 256);
          if (r >= 16.0) begin
            real d;
            d = real'(out_mag) - em;
            if (d < 0.0) d = -d;
            chk(d <= 6.0 + em/32.0, "R5 magnitude", out_mag, int'(em));
          end
          if (r >= 64.0) begin
            real d;
            ep = $atan2(real'(aq), real'(ai)) * 512.0 / PI;
            d  = real'(out_phase) - ep;
            if (d < 0.0) d = -d;
            chk(d <= 5.0, "R6 phase", out_phase, int'(ep));
          end
          if (ai == 0 && aq == 0)
            chk(out_mag == 0, "R9 zero magnitude", out_mag, 0);
          if (ai == last_ai && aq == last_aq) begin
            chk(out_mag == last_mag, "R7 mirror magnitude", out_mag, last_mag);
            chk(out_phase == last_ph, "R7 mirror phase", out_phase, last_ph);
          end
          last_ai = ai; last_aq = aq; last_mag = out_mag; last_ph = out_phase;
        end else begin
          chk(out_mag == prev_mag && out_phase == prev_ph, "R8 hold mag/phase",
              out_mag, prev_mag);
          chk(out_i_neg == prev_ni && out_q_neg == prev_nq, "R8 hold flags",
              {out_i_neg, out_q_neg}, prev_ni*2 + prev_nq);
        end
      end
      prev_mag = out_mag; prev_ph = out_phase; prev_ni = out_i_neg; prev_nq = out_q_neg;
    end
  end

  task automatic send(input int i, input int q);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 8'(i);
    in_q = 8'(q);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_i = 8'h5A;
      in_q = 8'hA5;
    end
  endtask

  task automatic mirror(input int i, input int q);
    send(i, q); send(-i, q); send(i, -q); send(-i, -q);
  endtask

  initial begin
    int seed;
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid low", out_valid, 0);
    chk(out_mag == 0, "R1 reset magnitude", out_mag, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid low after release", out_valid, 0);
    mon_on = 1;

    // axes and diagonals
    send(64, 0); send(0, 64); send(-100, 0); send(0, -128);
    idle(3);
    send(90, 90); send(-128, -128); send(127, -127);
    idle(12);
    // sign variants, back to back
    mirror(100, 37); mirror(-128, 5); mirror(20, 120); mirror(70, 70);
    idle(12);
    // zero and tiny
    send(0, 0); idle(2); send(3, -2); send(0, 0);
    idle(12);
    // stream with gaps
    seed = 12345;
    for (int n = 0; n < 400; n++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
      if ((seed >> 20) % 5 == 0) idle(1 + (seed >> 8) % 3);
      send((seed >> 4) % 256 - 128, (seed >> 12) % 256 - 128);
    end
    idle(20);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule